// File: doc/BRIEF.md
# Configurable-Framing Serial Transmitter

This block turns bytes into asynchronous serial characters on a single transmit line. A byte is written into a one-word holding register. When the shift engine is free, and the clear-to-send condition allows it, the byte moves into the shift engine. It is then sent as a start bit (0), five to eight data bits least significant bit first, an optional parity bit, and one, one-and-a-half or two stop bits (1). The idle line is 1.

The framing comes from a line-control input. It selects the word length, the stop length, whether a parity bit is sent, and what kind of parity. A break bit forces the line low at any time. Bit timing comes from an external enable pulse at sixteen times the bit rate, so every bit lasts sixteen pulses and a half stop bit lasts eight. Two status outputs tell the producer when it may write the next byte and when the line has fully drained.

Top module: `serial_tx_framer`

## Requirements
- R1: A character is a start bit of 0 followed by the data bits, least significant first. The count of data bits is 5, 6, 7 or 8 when line_ctl[1:0] is 00, 01, 10 or 11.
- R2: With line_ctl[2] clear the stop period is 16 ticks. With it set the stop period is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. The stop level is 1.
- R3: With line_ctl[3] set, one parity bit of 16 ticks follows the last data bit and comes before the stop period. With it clear, no parity bit is sent.
- R4: With parity on and line_ctl[5] clear, line_ctl[4]=1 makes the count of ones over the data and parity bits even, and line_ctl[4]=0 makes it odd.
- R5: With parity on and line_ctl[5] set, the parity bit is the inverse of line_ctl[4]. A line_ctl value of 0x28 sends 1 and 0x38 sends 0, whatever the data.
- R6: While line_ctl[6] is set, txd is 0 from the same cycle on, in idle or mid-character. The character keeps its timing underneath, and its remaining bits and end time are unchanged once the break is released.
- R7: hold_empty is high whenever the holding register is free, including while a character is shifting. It goes low the cycle after an accepted write. A write while the holding register is full is ignored.
- R8: tx_empty is high only when both the holding register and the shift engine are empty, and txd is then 1. A byte waiting at the end of a stop period starts in the next bit with no idle gap.
- R9: With cts_gate_en high and cts_n high, no new character starts. A character already started completes. With cts_gate_en low, cts_n has no effect.
- R10: The framing fields line_ctl[5:0] are captured when a character starts. Later changes to them do not alter that character.
- R11: Timing advances only on cycles with bit_tick high. Each start, data and parity bit lasts 16 ticks. Without ticks, txd holds its value.
- R12: After reset, txd is 1, and hold_empty and tx_empty are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send (low bits used for short words) |
| line_ctl | input | 7 | Framing control: [1:0] length, [2] long stop, [3] parity on, [4] even/stick value, [5] stick, [6] break |
| cts_n | input | 1 | Clear to send, active low |
| cts_gate_en | input | 1 | When high, a new character waits for cts_n low |
| bit_tick | input | 1 | Enable pulse at sixteen times the bit rate |
| txd | output | 1 | Serial transmit line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shift engine both empty |

## Verification
A stuck bit counter or a wrong stop-length choice shows as tx_empty rising early or late. The error is visible to the exact cycle at the end of that same character, so the frame length is checked at the cycle it should occur. A wrong data, parity or shift state shows as a bad level at the middle of the affected bit, within 16 ticks of the fault. A holding register that accepts an overwrite, or that releases too late, changes which byte appears in the next frame and when that frame's start bit falls. Break and clear-to-send faults show within one cycle on txd or as a character that starts when it must not.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int BYTE_W = 8;
    localparam int CTL_W  = 7;

    // line_ctl field positions (decoded by the framing logic)
    localparam int CTL_STOP  = 2;
    localparam int CTL_PAR   = 3;
    localparam int CTL_EVEN  = 4;
    localparam int CTL_STICK = 5;
    localparam int CTL_BRK   = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       long_stop;
        logic       par_on;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    function automatic frame_cfg_t cfg_from_ctl(input logic [5:0] c);
        frame_cfg_t f;
        f.wlen      = c[1:0];
        f.long_stop = c[CTL_STOP];
        f.par_on    = c[CTL_PAR];
        f.par_even  = c[CTL_EVEN];
        f.par_stick = c[CTL_STICK];
        return f;
    endfunction

    function automatic logic [3:0] word_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    function automatic logic parity_of(input frame_cfg_t f, input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] m;
        m = d & (8'hFF >> (2'd3 - f.wlen));
        if (f.par_stick)
            return ~f.par_even;
        else if (f.par_even)
            return ^m;
        else
            return ~(^m);
    endfunction

    function automatic int unsigned stop_len(input frame_cfg_t f, input int unsigned ovs);
        if (!f.long_stop)
            return ovs;
        else if (f.wlen == 2'b00)
            return ovs + ovs / 2;
        else
            return 2 * ovs;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (take) begin
            valid <= 1'b0;
        end else if (wr_en && !valid) begin
            valid <= 1'b1;
            data  <= wr_data;
        end
    end

endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int OVERSAMPLE = 16,
    localparam int LEN_W = $clog2(2 * OVERSAMPLE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [LEN_W-1:0] len,
    output logic             phase_end
);

    logic [LEN_W-1:0] cnt;

    assign phase_end = tick && (cnt == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (phase_end)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    localparam int LEN_W = $clog2(2 * OVERSAMPLE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              hold_valid,
    input  logic [BYTE_W-1:0] hold_data,
    input  frame_cfg_t        cfg_in,
    input  logic              cts_ok,
    output logic              take,
    output logic              line_bit,
    output logic              idle
);

    phase_e            phase;
    frame_cfg_t        cfg;
    logic [BYTE_W-1:0] shreg;
    logic [2:0]        bit_idx;
    logic              par_bit;
    logic              phase_end;
    logic              launch;
    logic              last_data;
    logic [LEN_W-1:0]  len;

    always_comb begin
        if (phase == PH_STOP)
            len = LEN_W'(stop_len(cfg, OVERSAMPLE));
        else
            len = LEN_W'(OVERSAMPLE);
    end

    sertx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_tick),
        .restart  (launch),
        .len      (len),
        .phase_end(phase_end)
    );

    assign launch    = hold_valid && cts_ok &&
                       ((phase == PH_IDLE) || (phase == PH_STOP && phase_end));
    assign take      = launch;
    assign idle      = (phase == PH_IDLE);
    assign last_data = ({1'b0, bit_idx} == word_bits(cfg.wlen) - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cfg     <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            par_bit <= 1'b0;
        end else if (launch) begin
            phase   <= PH_START;
            cfg     <= cfg_in;
            shreg   <= hold_data;
            bit_idx <= '0;
            par_bit <= parity_of(cfg_in, hold_data);
        end else if (phase_end) begin
            case (phase)
                PH_START: phase <= PH_DATA;
                PH_DATA: begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 3'd1;
                    if (last_data)
                        phase <= cfg.par_on ? PH_PARITY : PH_STOP;
                end
                PH_PARITY: phase <= PH_STOP;
                PH_STOP:   phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_START:  line_bit = 1'b0;
            PH_DATA:   line_bit = shreg[0];
            PH_PARITY: line_bit = par_bit;
            default:   line_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CTL_W-1:0]  line_ctl,
    input  logic              cts_n,
    input  logic              cts_gate_en,
    input  logic              bit_tick,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    logic              hold_valid;
    logic [BYTE_W-1:0] hold_data;
    logic              take;
    logic              line_bit;
    logic              sh_idle;
    logic              cts_ok;
    frame_cfg_t        cfg_now;

    assign cts_ok  = !cts_gate_en || !cts_n;
    assign cfg_now = cfg_from_ctl(line_ctl[5:0]);

    sertx_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .take   (take),
        .valid  (hold_valid),
        .data   (hold_data)
    );

    sertx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .hold_valid(hold_valid),
        .hold_data (hold_data),
        .cfg_in    (cfg_now),
        .cts_ok    (cts_ok),
        .take      (take),
        .line_bit  (line_bit),
        .idle      (sh_idle)
    );

    assign txd        = line_ctl[CTL_BRK] ? 1'b0 : line_bit;
    assign hold_empty = !hold_valid;
    assign tx_empty   = !hold_valid && sh_idle;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] line_ctl,
    input logic       cts_n,
    input logic       cts_gate_en,
    input logic       bit_tick,
    input logic       txd,
    input logic       hold_empty,
    input logic       tx_empty,
    input logic       sh_idle
);

    assert_empty_needs_hold_R8: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);

    assert_idle_is_mark_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !line_ctl[6]) |-> txd);

    assert_release_starts_char_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_empty) |-> !tx_empty);

    assert_cts_holds_start_R9: assert property (@(posedge clk) disable iff (rst)
        (sh_idle && cts_gate_en && cts_n) |=> sh_idle);

    assert_start_bit_low_R1: assert property (@(posedge clk) disable iff (rst)
        ($fell(sh_idle) && !line_ctl[6]) |-> !txd);

    assert_no_tick_no_move_R11: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && !sh_idle) |=> (txd == $past(txd) || line_ctl[6] != $past(line_ctl[6])));

endmodule

bind serial_tx_framer sertx_chk u_sertx_chk (
    .clk        (clk),
    .rst        (rst),
    .line_ctl   (line_ctl),
    .cts_n      (cts_n),
    .cts_gate_en(cts_gate_en),
    .bit_tick   (bit_tick),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .sh_idle    (sh_idle)
);

// File: tb/test_serial_tx_framer.sv
module test_serial_tx_framer;

    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] line_ctl = 7'h03;
    logic       cts_n = 1'b0;
    logic       cts_gate_en = 1'b0;
    logic       bit_tick = 1'b1;
    logic       txd, hold_empty, tx_empty;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_tx_framer #(.OVERSAMPLE(OVS)) i_serial_tx_framer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .line_ctl(line_ctl), .cts_n(cts_n), .cts_gate_en(cts_gate_en),
        .bit_tick(bit_tick), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Expected frame: bit levels per 16-tick slot, slot count before stop, total ticks
    function automatic void build(input logic [7:0] d, input logic [6:0] lc,
                                  output logic [11:0] bits, output int nslots, output int len);
        int  n;
        int  p;
        int  ones;
        logic par;
        n    = 5 + int'(lc[1:0]);
        p    = lc[3] ? 1 : 0;
        ones = 0;
        for (int i = 0; i < n; i++) ones += int'(d[i]);
        if (lc[5])      par = ~lc[4];
        else if (lc[4]) par = (ones % 2 == 1);
        else            par = (ones % 2 == 0);
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < n; i++) bits[1 + i] = d[i];
        if (p == 1) bits[1 + n] = par;
        nslots = 1 + n + p;
        len = OVS * nslots + (!lc[2] ? OVS : (n == 5 ? OVS + OVS / 2 : 2 * OVS));
    endfunction

    // Called at the negedge where the start bit is first visible (k = 0).
    task automatic check_frame(input logic [7:0] d, input logic [6:0] lc, input bit expect_more,
                               input int wr_at, input logic [7:0] wr_d,
                               input int stall_at, input bit scramble);
        logic [11:0] bits;
        int nslots, len;
        logic held;
        string tag;
        build(d, lc, bits, nslots, len);
        for (int k = 0; k <= len; k++) begin
            if (k > 0) @(negedge clk);
            if (k < len) begin
                chk(tx_empty === 1'b0, "R8 busy", int'(tx_empty), 0);
                if (k % OVS == OVS / 2) begin
                    if (k / OVS == 0 || k / OVS < 6 + int'(lc[1:0])) tag = "R1 start/data";
                    else if (k / OVS < nslots) tag = lc[5] ? "R5 stick parity" : "R4 parity";
                    else tag = "R2 stop";
                    chk(txd === bits[k / OVS], tag, int'(txd), int'(bits[k / OVS]));
                end
            end else begin
                if (expect_more)
                    chk(tx_empty === 1'b0 && txd === 1'b0, "R8 back-to-back start", int'(txd), 0);
                else
                    chk(tx_empty === 1'b1 && txd === 1'b1, "R2 R3 frame length", int'(tx_empty), 1);
            end
            if (scramble && k == 1) line_ctl = 7'($urandom) & 7'h3F;   // R10
            if (wr_at >= 0) begin
                if (k == wr_at - 1) chk(hold_empty === 1'b1, "R7 free while shifting", int'(hold_empty), 1);
                if (k == wr_at) begin wr_en = 1'b1; wr_data = wr_d; end
                if (k == wr_at + 1) begin
                    wr_en = 1'b0;
                    chk(hold_empty === 1'b0, "R7 full after write", int'(hold_empty), 0);
                end
                if (k == wr_at + 20) begin wr_en = 1'b1; wr_data = ~wr_d; end
                if (k == wr_at + 21) wr_en = 1'b0;
            end
            if (k == stall_at) begin
                bit_tick = 1'b0;
                held = txd;
                repeat (40) begin
                    @(negedge clk);
                    chk(txd === held && tx_empty === 1'b0, "R11 stall", int'(txd), int'(held));
                end
                bit_tick = 1'b1;
            end
        end
    endtask

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd === 1'b0) begin seen = 1'b1; break; end
        end
        chk(seen, "R9 start seen", int'(seen), 1);
    endtask

    task automatic send(input logic [7:0] d, input logic [6:0] lc, input bit scramble, input int stall_at);
        bit seen;
        @(negedge clk);
        line_ctl = lc; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wait_start(seen);
        if (seen) check_frame(d, lc, 1'b0, -1, 8'h00, stall_at, scramble);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd7391));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R12 txd", int'(txd), 1);
        chk(hold_empty === 1'b1, "R12 hold_empty", int'(hold_empty), 1);
        chk(tx_empty === 1'b1, "R12 tx_empty", int'(tx_empty), 1);

        // R1 word lengths, R2 stop lengths
        send(8'hA5, 7'h03, 1'b0, -1);
        send(8'h1A, 7'h04, 1'b0, -1);   // 5 bits, 1.5 stop
        send(8'h2D, 7'h05, 1'b0, -1);   // 6 bits, 2 stop
        send(8'h4E, 7'h06, 1'b0, -1);   // 7 bits, 2 stop
        send(8'hC3, 7'h00, 1'b0, -1);   // 5 bits, 1 stop
        // R3 R4 parity, R5 stick parity
        send(8'h37, 7'h1B, 1'b0, -1);
        send(8'h37, 7'h0B, 1'b0, -1);
        send(8'h00, 7'h2B, 1'b0, -1);
        send(8'hFF, 7'h3B, 1'b0, -1);
        send(8'h15, 7'h28, 1'b0, -1);
        send(8'h15, 7'h38, 1'b0, -1);
        // R11 tick stall mid-character
        send(8'h96, 7'h0F, 1'b0, 37);

        // R7 R8 back-to-back with an ignored overwrite
        @(negedge clk);
        line_ctl = 7'h03; wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        wait_start(seen);
        if (seen) begin
            check_frame(8'h5A, 7'h03, 1'b1, 20, 8'hC6, -1, 1'b0);
            check_frame(8'hC6, 7'h03, 1'b0, -1, 8'h00, -1, 1'b0);
        end

        // R9 clear-to-send gating
        cts_gate_en = 1'b1; cts_n = 1'b1;
        @(negedge clk);
        line_ctl = 7'h03; wr_en = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (50) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b0 && hold_empty === 1'b0, "R9 blocked", int'(txd), 1);
        cts_n = 1'b0;
        @(negedge clk);
        chk(txd === 1'b0, "R9 released", int'(txd), 0);
        cts_n = 1'b1;                    // deasserts mid-character
        check_frame(8'h3C, 7'h03, 1'b0, -1, 8'h00, -1, 1'b0);
        cts_gate_en = 1'b0;              // gate off: cts_n ignored
        send(8'h81, 7'h03, 1'b0, -1);
        cts_n = 1'b0;

        // R6 break in idle
        @(negedge clk);
        line_ctl = 7'h43;
        @(negedge clk);
        chk(txd === 1'b0 && tx_empty === 1'b1, "R6 idle break", int'(txd), 0);
        line_ctl = 7'h03;
        @(negedge clk);
        chk(txd === 1'b1, "R6 idle release", int'(txd), 1);

        // R6 break mid-character keeps timing
        wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        wait_start(seen);
        for (int k = 1; k <= 10 * OVS; k++) begin
            @(negedge clk);
            if (k == 20) line_ctl = 7'h43;
            if (k > 20 && k <= 60) chk(txd === 1'b0, "R6 break low", int'(txd), 0);
            if (k == 60) line_ctl = 7'h03;
            if (k == 88) chk(txd === 1'b1, "R6 data after break", int'(txd), 1);
            if (k < 10 * OVS) chk(tx_empty === 1'b0, "R6 timing busy", int'(tx_empty), 0);
            else chk(tx_empty === 1'b1, "R6 timing end", int'(tx_empty), 1);
        end

        // Random framings and data, framing scrambled after start (R10)
        for (int i = 0; i < 30; i++) begin
            send(8'($urandom), 7'($urandom) & 7'h3F, 1'b1, -1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule